// File: doc/BRIEF.md
# Maskable Interrupt Latch with Write-to-Clear

This block gathers event pulses from five interrupt sources (external pin, timer 1, timer 2, asynchronous serial port, synchronous serial port) and turns them into one level-sensitive request for a host CPU. Each source owns one sticky pending bit. A source event sets that bit only when the source is enabled and an upstream master-enable input is high. The request output stays high while any pending bit is set.

The host reaches the block through one 16-bit register with split semantics. A write loads the enable mask from the low byte. The same write clears, with write-one-to-clear semantics, the pending bits selected in the high byte. A read returns the pending bits and never the enable mask. The request output comes from a two-state machine. Its states are `ST_QUIET` (no pending bit) and `ST_RAISED` (at least one pending bit). The transition `RAISE` goes from `ST_QUIET` to `ST_RAISED` when the next pending vector is non-zero. The transition `DROP` goes back when the next pending vector is all zero. Every other case holds the state.

Top module: `irqc_latch_top`

## Requirements
- R1: After reset, the pending bits read as 0 and `irq_out` is low. The enable mask is also 0, so events arriving right after reset do not latch.
- R2: A write loads the enable mask from `wr_data[4:0]`: bit 0 external, bit 1 timer 1, bit 2 timer 2, bit 3 asynchronous serial, bit 4 synchronous serial. Bits 7:5 have no effect.
- R3: An event on `evt_in[i]` while enable bit i is set and `gate_in` is high sets pending bit i at that clock edge. `evt_in` uses the same bit order as the enable mask.
- R4: While `gate_in` is low, no event sets any pending bit.
- R5: A write with `wr_data[8+i]` = 1 clears pending bit i. Pending bits whose clear bit is 0 keep their value.
- R6: `rd_data[4:0]` returns the pending bits in enable order. `rd_data[15:5]` reads 0.
- R7: `irq_out` is high exactly when at least one pending bit is set, and it stays high until software clears all of them.
- R8: When an event that qualifies under R3 and a clear for the same bit arrive in the same cycle, the bit is pending afterwards.
- R9: An event is qualified by the enable mask held before the clock edge. An enable written in the same cycle first applies to events of the next cycle.
- R10: Clearing an enable bit does not clear its pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data: [4:0] enables, [12:8] clear bits |
| rd_data | output | 16 | Read data: pending bits in [4:0] |
| gate_in | input | 1 | Upstream master enable for latching |
| evt_in | input | 5 | Per-source event pulses |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to set up is a single cycle in which a write clears a bit while an event for the same bit arrives. The enable for that bit must already have been written in an earlier cycle, and the gate must be high. The stimulus first arms the enable, latches the bit once, and then drives the clear and the event together on one negative edge. A second case writes a new enable together with an event. It shows that the enable written on that edge does not yet qualify the event, and that the event latches one cycle later.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    parameter int unsigned IRQC_NUM_SRC  = 5;
    parameter int unsigned IRQC_REG_W    = 16;
    parameter int unsigned IRQC_CLR_BASE = 8;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irqc_state_e;
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] en_o
);
    // Enable mask: loaded on every register write, cleared on reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (wr_i) begin
            en_o <= d_i;
        end
    end
endmodule

// File: rtl/irqc_src_slice.sv
module irqc_src_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic gate_i,
    input  logic evt_i,
    input  logic clr_i,
    output logic pend_o,
    output logic pend_nxt_o
);
    logic set_w;

    // A qualified event overrides a clear in the same cycle.
    always_comb begin
        set_w      = evt_i & en_i & gate_i;
        pend_nxt_o = (pend_o & ~clr_i) | set_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
        end else begin
            pend_o <= pend_nxt_o;
        end
    end
endmodule

// File: rtl/irqc_req_fsm.sv
module irqc_req_fsm
    import irqc_pkg::*;
#(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_nxt_i,
    output logic         irq_o
);
    irqc_state_e state_q, state_d;
    logic        any_nxt;

    always_comb begin
        any_nxt = |pend_nxt_i;
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (any_nxt)  state_d = ST_RAISED;  // RAISE
            ST_RAISED: if (!any_nxt) state_d = ST_QUIET;   // DROP
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == ST_RAISED);
    end
endmodule

// File: rtl/irqc_latch_top.sv
module irqc_latch_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC  = IRQC_NUM_SRC,
    parameter int unsigned REG_W    = IRQC_REG_W,
    parameter int unsigned CLR_BASE = IRQC_CLR_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               gate_in,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic               irq_out
);
    localparam int unsigned PAD_W = REG_W - NUM_SRC;

    logic [NUM_SRC-1:0] en_w;
    logic [NUM_SRC-1:0] clr_w;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] pend_nxt_w;

    irqc_mask_reg #(.N(NUM_SRC)) u_mask (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_i (wr_en),
        .d_i  (wr_data[NUM_SRC-1:0]),
        .en_o (en_w)
    );

    assign clr_w = wr_en ? wr_data[CLR_BASE +: NUM_SRC] : '0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irqc_src_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en_w[g]),
            .gate_i    (gate_in),
            .evt_i     (evt_in[g]),
            .clr_i     (clr_w[g]),
            .pend_o    (pend_w[g]),
            .pend_nxt_o(pend_nxt_w[g])
        );
    end

    irqc_req_fsm #(.N(NUM_SRC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_nxt_i(pend_nxt_w),
        .irq_o     (irq_out)
    );

    assign rd_data = {{PAD_W{1'b0}}, pend_w};
endmodule

// File: rtl/irqc_latch_chk.sv
module irqc_latch_chk #(
    parameter int unsigned NUM_SRC  = 5,
    parameter int unsigned REG_W    = 16,
    parameter int unsigned CLR_BASE = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REG_W-1:0]   wr_data,
    input logic [REG_W-1:0]   rd_data,
    input logic               gate_in,
    input logic [NUM_SRC-1:0] evt_in,
    input logic               irq_out
);
    logic [NUM_SRC-1:0] en_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_sh <= '0;
        else if (wr_en) en_sh <= wr_data[NUM_SRC-1:0];
    end

    AST_IRQ_MATCHES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|rd_data[NUM_SRC-1:0])); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:NUM_SRC] == '0); // R6

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        AST_QUALIFIED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_in[g] && gate_in && en_sh[g]) |=> rd_data[g]); // R8

        AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (!gate_in && !rd_data[g]) |=> !rd_data[g]); // R4

        AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[CLR_BASE+g] && !(evt_in[g] && gate_in && en_sh[g]))
                |=> !rd_data[g]); // R5

        AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[g] && !(wr_en && wr_data[CLR_BASE+g])) |=> rd_data[g]); // R10

        AST_NO_UNQUALIFIED_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_data[g] && !(evt_in[g] && gate_in && en_sh[g])) |=> !rd_data[g]); // R3
    end
endmodule

bind irqc_latch_top irqc_latch_chk #(
    .NUM_SRC (NUM_SRC),
    .REG_W   (REG_W),
    .CLR_BASE(CLR_BASE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .gate_in(gate_in),
    .evt_in (evt_in),
    .irq_out(irq_out)
);

// File: tb/tb_irqc_latch_top.sv
`timescale 1ns/1ps
module tb_irqc_latch_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        gate_in = 1'b0;
    logic [4:0]  evt_in = '0;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irqc_latch_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .gate_in(gate_in), .evt_in(evt_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle of stimulus at the negedge, then return to idle after the next negedge.
    task automatic step(input logic w, input logic [15:0] d, input logic [4:0] e, input logic g);
        wr_en = w; wr_data = d; evt_in = e; gate_in = g;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; evt_in = '0;
    endtask

    task automatic clear_all();
        step(1'b1, 16'h1F00, 5'h0, gate_in);
    endtask

    task automatic t_reset();
        chk("R1 pending", rd_data, 16'h0000);
        chk("R1 irq", {15'h0, irq_out}, 16'h0001 & 16'h0);
        step(1'b0, 16'h0, 5'h1F, 1'b1);
        chk("R1 no latch with reset mask", rd_data, 16'h0000);
    endtask

    task automatic t_each_source();
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 16'h0001 << i, 5'h0, 1'b1);
            step(1'b0, 16'h0, 5'h1F, 1'b1);
            chk("R2/R3 single source latch", rd_data, 16'h0001 << i);
            chk("R7 irq high", {15'h0, irq_out}, 16'h0001);
            clear_all();
        end
        chk("R7 irq low after clear", {15'h0, irq_out}, 16'h0000);
    endtask

    task automatic t_upper_enable_ignored();
        step(1'b1, 16'h00E0, 5'h0, 1'b1);
        step(1'b0, 16'h0, 5'h1F, 1'b1);
        chk("R2 bits 7:5 ignored", rd_data, 16'h0000);
    endtask

    task automatic t_gate();
        step(1'b1, 16'h001F, 5'h0, 1'b0);
        step(1'b0, 16'h0, 5'h1F, 1'b0);
        chk("R4 gate low blocks", rd_data, 16'h0000);
        chk("R4 irq stays low", {15'h0, irq_out}, 16'h0000);
        step(1'b0, 16'h0, 5'h15, 1'b1);
        chk("R3 gate high latches", rd_data, 16'h0015);
    endtask

    task automatic t_clear_select();
        step(1'b0, 16'h0, 5'h1F, 1'b1);
        step(1'b1, 16'h0A1F, 5'h0, 1'b1);
        chk("R5 selective clear", rd_data, 16'h0015);
        chk("R6 read returns pending, not enables", rd_data & 16'hFFE0, 16'h0000);
        step(1'b1, 16'h111F, 5'h0, 1'b1);
        chk("R5 second clear", rd_data, 16'h0004);
        chk("R7 irq held by remaining bit", {15'h0, irq_out}, 16'h0001);
        clear_all();
    endtask

    task automatic t_collision();
        step(1'b1, 16'h0008, 5'h0, 1'b1);
        step(1'b0, 16'h0, 5'h08, 1'b1);
        chk("R8 armed", rd_data, 16'h0008);
        step(1'b1, 16'h0808, 5'h08, 1'b1);
        chk("R8 event wins over clear", rd_data, 16'h0008);
        chk("R8 irq remains", {15'h0, irq_out}, 16'h0001);
        clear_all();
    endtask

    task automatic t_enable_timing();
        step(1'b1, 16'h0000, 5'h0, 1'b1);
        step(1'b1, 16'h0002, 5'h02, 1'b1);
        chk("R9 new enable not yet active", rd_data, 16'h0000);
        step(1'b0, 16'h0, 5'h02, 1'b1);
        chk("R9 enable active next cycle", rd_data, 16'h0002);
        clear_all();
    endtask

    task automatic t_sticky();
        step(1'b1, 16'h0010, 5'h0, 1'b1);
        step(1'b0, 16'h0, 5'h10, 1'b1);
        step(1'b1, 16'h0000, 5'h0, 1'b1);
        chk("R10 pending survives disable", rd_data, 16'h0010);
        step(1'b0, 16'h0, 5'h0, 1'b0);
        chk("R7 irq held until cleared", {15'h0, irq_out}, 16'h0001);
        clear_all();
        chk("R7 irq drops after clear", {15'h0, irq_out}, 16'h0000);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog all-requirements act=timeout exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_each_source();
        t_upper_enable_ignored();
        t_gate();
        t_clear_select();
        t_collision();
        t_enable_timing();
        t_sticky();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule